// File: doc/BRIEF.md
# Command-Block CRC-32 Engine

This block protects command blocks with a 32-bit checksum. A stream of bytes arrives one per clock, qualified by a valid strobe. The engine folds each byte into a running remainder. It processes the most significant bit first, uses no bit reflection and applies no final inversion. The generator is x^32 + x^29 + x^18 + x^14 + x^3 + 1, which is 0x20044009 in normal form. This is not the usual Ethernet generator.

A start pulse begins a new computation. By default it loads the all-ones seed. When the external-seed select is high, it loads a caller-supplied seed instead, so a checksum over a long buffer can be resumed from an earlier partial result. If start and valid are both high in the same cycle, the seed is loaded and the first byte is absorbed in that one clock. The output always shows the raw remainder register.

Top module: `cmdcrc_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, crc_o equals 0xFFFFFFFF.
- R2: A cycle with valid_i=1 and start_i=0 updates the remainder as follows. The data byte is XORed into bits 31:24. Then, eight times, the register is shifted left by one bit, and the result is XORed with 0x20044009 if the bit shifted out was 1. The new value appears on crc_o after that clock edge.
- R3: Starting from the all-ones seed, the bytes 0x01, 0x02, 0x03, 0x04 yield crc_o = 0xF33CB7D3, the raw register value with no final XOR and no reflection.
- R4: start_i=1 with seed_sel_i=0 loads 0xFFFFFFFF. If valid_i is also 1, the byte is absorbed into that seed in the same cycle.
- R5: start_i=1 with seed_sel_i=1 loads seed_i instead, with or without a byte absorbed in the same cycle.
- R6: When valid_i=0 and start_i=0, crc_o keeps its value. data_i, seed_i and seed_sel_i have no effect.
- R7: Take the partial result after bytes A and restart with it as the external seed. Feeding bytes B from there gives the same value as feeding A followed by B from the all-ones seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Begin a new computation by loading the seed |
| seed_sel_i | input | 1 | 1 selects seed_i as the seed, 0 selects all-ones |
| seed_i | input | 32 | External seed, used to continue a running checksum |
| valid_i | input | 1 | data_i holds a byte to absorb this cycle |
| data_i | input | 8 | Data byte |
| crc_o | output | 32 | Current remainder, raw |

## Verification
The assertions assume that start_i, valid_i, seed_sel_i and seed_i are always at known levels once reset is released. They also assume that start and valid may arrive in any combination, including both in the same cycle. The stimulus drives every input to a defined value in every cycle, including during reset. Its random phase draws start, select and valid independently, so all combinations occur alongside directed cases for the known vector, restarts and resumption from a partial result.

// File: rtl/cmdcrc_pkg.sv
package cmdcrc_pkg;
  localparam int CRC_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int LUT_DEPTH = 1 << BYTE_W;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Remainder of one byte value placed in the top bits, shifted out MSB first.
  function automatic crc_t lut_entry(input byte_t idx, input crc_t poly);
    crc_t r;
    r = crc_t'(idx) << (CRC_W - BYTE_W);
    for (int s = 0; s < BYTE_W; s++) begin
      if (r[CRC_W-1]) r = (r << 1) ^ poly;
      else            r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/cmdcrc_lut.sv
module cmdcrc_lut
  import cmdcrc_pkg::*;
#(
  parameter crc_t POLY = 32'h2004_4009
) (
  input  byte_t idx_i,
  output crc_t  entry_o
);
  crc_t tbl [LUT_DEPTH];

  for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_entry
    assign tbl[g] = lut_entry(byte_t'(g), POLY);
  end

  assign entry_o = tbl[idx_i];
endmodule

// File: rtl/cmdcrc_byte_step.sv
module cmdcrc_byte_step
  import cmdcrc_pkg::*;
#(
  parameter crc_t POLY = 32'h2004_4009
) (
  input  crc_t  crc_i,
  input  byte_t byte_i,
  output crc_t  crc_o
);
  byte_t idx;
  crc_t  entry;

  assign idx = crc_i[CRC_W-1 -: BYTE_W] ^ byte_i;

  cmdcrc_lut #(.POLY(POLY)) u_lut (
    .idx_i   (idx),
    .entry_o (entry)
  );

  assign crc_o = (crc_i << BYTE_W) ^ entry;
endmodule

// File: rtl/cmdcrc_seed_sel.sv
module cmdcrc_seed_sel
  import cmdcrc_pkg::*;
#(
  parameter crc_t INIT = 32'hFFFF_FFFF
) (
  input  logic start_i,
  input  logic seed_sel_i,
  input  crc_t seed_i,
  input  crc_t cur_i,
  output crc_t base_o
);
  always_comb begin
    if (!start_i)        base_o = cur_i;
    else if (seed_sel_i) base_o = seed_i;
    else                 base_o = INIT;
  end
endmodule

// File: rtl/cmdcrc_engine.sv
module cmdcrc_engine
  import cmdcrc_pkg::*;
#(
  parameter logic [31:0] POLY = 32'h2004_4009,
  parameter logic [31:0] INIT = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        seed_sel_i,
  input  logic [31:0] seed_i,
  input  logic        valid_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  crc_t crc_q, crc_d, base, stepped;
  logic en;

  cmdcrc_seed_sel #(.INIT(INIT)) u_seed (
    .start_i    (start_i),
    .seed_sel_i (seed_sel_i),
    .seed_i     (seed_i),
    .cur_i      (crc_q),
    .base_o     (base)
  );

  cmdcrc_byte_step #(.POLY(POLY)) u_step (
    .crc_i  (base),
    .byte_i (data_i),
    .crc_o  (stepped)
  );

  // next state
  always_comb begin
    en    = start_i | valid_i;
    crc_d = valid_i ? stepped : base;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= INIT;
    else if (en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/cmdcrc_checker.sv
module cmdcrc_checker #(
  parameter logic [31:0] INIT = 32'hFFFF_FFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        seed_sel_i,
  input logic [31:0] seed_i,
  input logic        valid_i,
  input logic [31:0] crc_o
);
  AST_RESET_VALUE: assert property (@(posedge clk) $rose(rst_n) |-> crc_o == INIT); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !valid_i) |=> $stable(crc_o)); // R6
  AST_START_DEFAULT_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_i && !seed_sel_i) |=> crc_o == INIT); // R4
  AST_START_EXT_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_i && seed_sel_i) |=> crc_o == $past(seed_i)); // R5
  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(crc_o)); // R2
endmodule

bind cmdcrc_engine cmdcrc_checker #(.INIT(INIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .seed_sel_i (seed_sel_i),
  .seed_i     (seed_i),
  .valid_i    (valid_i),
  .crc_o      (crc_o)
);

// File: tb/test_cmdcrc_engine.sv
`timescale 1ns/1ps
module test_cmdcrc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, seed_sel_i = 1'b0, valid_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic [7:0]  data_i = '0;
  logic [31:0] crc_o;

  int nvec = 0, nbad = 0;
  logic [31:0] exp_crc;
  bit finished = 0;

  always #2 clk = ~clk;

  cmdcrc_engine i_cmdcrc_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_sel_i(seed_sel_i),
    .seed_i(seed_i), .valid_i(valid_i), .data_i(data_i), .crc_o(crc_o)
  );

  function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {b, 24'h0};
    for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ 32'h2004_4009) : (r << 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    nvec++;
    if (crc_o !== exp) begin
      nbad++;
      $display("FAIL %s: crc_o=%08h expected=%08h", req, crc_o, exp);
    end
  endtask

  // drive one cycle, update model, check after the edge
  task automatic cyc(input string req, input bit st, input bit sel,
                     input logic [31:0] sd, input bit v, input logic [7:0] d);
    logic [31:0] base;
    @(negedge clk);
    start_i = st; seed_sel_i = sel; seed_i = sd; valid_i = v; data_i = d;
    base = st ? (sel ? sd : 32'hFFFF_FFFF) : exp_crc;
    exp_crc = v ? ref_byte(base, d) : base;
    @(posedge clk); #1;
    check(req, exp_crc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start_i = 0; valid_i = 0; seed_sel_i = 0;
    #1 exp_crc = 32'hFFFF_FFFF;
    check("R1", exp_crc);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", exp_crc);
  endtask

  initial begin
    logic [31:0] part, full;
    logic [7:0] bytes [8];
    void'($urandom(32'd1234));
    exp_crc = 32'hFFFF_FFFF;
    repeat (2) @(posedge clk);
    do_reset();

    // R3 known vector, R4 start with byte in same cycle
    cyc("R4", 1, 0, 32'h0, 1, 8'h01);
    cyc("R2", 0, 0, 32'h0, 1, 8'h02);
    cyc("R2", 0, 0, 32'h0, 1, 8'h03);
    cyc("R2", 0, 0, 32'h0, 1, 8'h04);
    check("R3", 32'hF33C_B7D3);

    // R6 idle with junk on other inputs
    cyc("R6", 0, 1, 32'h1234_5678, 0, 8'hA5);
    check("R6", 32'hF33C_B7D3);
    cyc("R6", 0, 0, 32'hDEAD_BEEF, 0, 8'h3C);

    // R4 start alone; R5 external seed with and without byte
    cyc("R4", 1, 0, 32'h5555_0000, 0, 8'h77);
    cyc("R5", 1, 1, 32'hCAFE_F00D, 0, 8'h00);
    cyc("R5", 1, 1, 32'h0000_0000, 1, 8'hFF);
    cyc("R2", 0, 0, 32'h0, 1, 8'h00);

    // R7 continuation
    for (int i = 0; i < 8; i++) bytes[i] = 8'($urandom);
    full = 32'hFFFF_FFFF;
    for (int i = 0; i < 8; i++) full = ref_byte(full, bytes[i]);
    cyc("R7", 1, 0, 32'h0, 1, bytes[0]);
    for (int i = 1; i < 4; i++) cyc("R7", 0, 0, 32'h0, 1, bytes[i]);
    part = crc_o;
    cyc("R7", 1, 0, 32'h0, 0, 8'h00);
    cyc("R7", 1, 1, part, 1, bytes[4]);
    for (int i = 5; i < 8; i++) cyc("R7", 0, 0, 32'h0, 1, bytes[i]);
    check("R7", full);

    // mid-run reset
    cyc("R2", 0, 0, 32'h0, 1, 8'h5A);
    do_reset();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit st, sel, v;
      st  = ($urandom % 8) == 0;
      sel = $urandom % 2;
      v   = ($urandom % 4) != 0;
      cyc(st ? (sel ? "R5" : "R4") : (v ? "R2" : "R6"),
          st, sel, $urandom, v, 8'($urandom));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: crc_o=%08h expected=%08h", crc_o, exp_crc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule